// File: doc/BRIEF.md
# Gated-Strobe Serial DAC Input Register

This block is the digital serial front end of a 12-bit multiplying DAC. A serial data bit is shifted into a 12-bit input shift register whenever an effective strobe edge occurs. Four strobe pins produce that edge. Three of them act on a rising edge, and one acts on a falling edge. Each strobe is honoured only while the other three rest in their idle levels. The bit pushed out of the top of the register appears on a serial output, so several devices can share one data line in a daisy chain.

Two active-low load pins move the shift register contents into the DAC register. The load is level-sensitive: while both pins are low, the DAC register tracks the shift register. An active-low clear forces the DAC register to zero at once, without waiting for a clock edge. The clear wins over a load, and it leaves the shift register untouched.

Every pin is sampled in one system clock domain through a two-flop synchronizer. The strobe pins are first merged into one level, and the block detects the rising edge of that level. The DAC register value is the block's output.

Top module: `dac_serial_front`

## Requirements
- R1: After a synchronous reset (`rst` high for at least one clock), `dac_word` and `sdo` are 0 and the shift register holds 0.
- R2: The shift register is 12 bits wide and is filled most significant bit first. The first `sdi` bit shifted in ends up in bit 11 of `dac_word` after twelve shifts and a load.
- R3: With `strb_c` high, a rising edge on exactly one of `strb_a`, `strb_b` or `strb_d` shifts in one bit, provided the other two are low. Pins are held at least 5 clocks between changes, and the shift takes effect within 4 clocks.
- R4: With `strb_a`, `strb_b` and `strb_d` all low, a falling edge on `strb_c` shifts in one bit.
- R5: A strobe edge that arrives while its gating condition does not hold causes no shift. Gating fails when another rising-edge strobe is high, or when `strb_c` is low, or, for a falling `strb_c`, when a rising-edge strobe is high.
- R6: On each shift, `sdo` takes the value of bit 11 that was shifted out, and holds it until the next shift. While a new word is clocked in, the previous word therefore leaves MSB first.
- R7: While `load_a_n` and `load_b_n` are both low, `dac_word` follows the shift register. This includes a load asserted right after the last strobe with no gap.
- R8: While either load pin is high, `dac_word` holds its value through any number of shifts.
- R9: `clr_n` low forces `dac_word` to 0 without waiting for a clock edge. It keeps `dac_word` at 0 even while both load pins are low.
- R10: A clear leaves the shift register unchanged, so a later load shows the word held before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_a | input | 1 | Rising-edge strobe, gated |
| strb_b | input | 1 | Rising-edge strobe, gated |
| strb_c | input | 1 | Falling-edge strobe, idle high |
| strb_d | input | 1 | Rising-edge strobe, gated |
| sdi | input | 1 | Serial data in |
| load_a_n | input | 1 | Load enable, active low, first of two |
| load_b_n | input | 1 | Load enable, active low, second of two |
| clr_n | input | 1 | Asynchronous clear of the DAC register, active low |
| sdo | output | 1 | Serial data out, the last bit shifted out |
| dac_word | output | DAC_BITS | DAC register contents |

## Verification
The assertions check on every cycle the following properties:
- A detected shift event moves the register up by one place, takes the synchronized data bit in at the bottom, and puts the old top bit on `sdo`.
- Without such an event, the register and `sdo` stay frozen.
- The DAC register copies the shift register whenever both synchronized loads are low, and holds otherwise.
- A low clear pins the DAC register to zero.

Only the bench scenarios can show the rest. These are the translation from the four strobe pins to shift events, including the blocked-edge cases. They also cover the daisy-chain order across two words, the clear taking effect between clock edges, and a shift register that is intact after a clear.

// File: rtl/dacsf_pkg.sv
package dacsf_pkg;
  // Pin bundle carried through the synchronizer
  typedef struct packed {
    logic strobe_any;
    logic data;
    logic ld_a_n;
    logic ld_b_n;
  } pin_s;

  localparam int PIN_BITS = $bits(pin_s);
  // Idle value: merged strobe high so no false edge right after reset
  localparam logic [PIN_BITS-1:0] PIN_IDLE = 4'b1011;
endpackage

// File: rtl/dacsf_sync.sv
module dacsf_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacsf_edge.sv
module dacsf_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/dacsf_shreg.sv
module dacsf_shreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      dout <= 1'b0;
    end else if (shift) begin
      word <= {word[W-2:0], din};
      dout <= word[W-1];
    end
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int DAC_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strb_a,
  input  logic                strb_b,
  input  logic                strb_c,
  input  logic                strb_d,
  input  logic                sdi,
  input  logic                load_a_n,
  input  logic                load_b_n,
  input  logic                clr_n,
  output logic                sdo,
  output logic [DAC_BITS-1:0] dac_word
);
  import dacsf_pkg::*;

  pin_s                raw;
  pin_s                synced;
  logic                shift_ev;
  logic                sdi_s;
  logic                ld_go;
  logic [DAC_BITS-1:0] sr_word;

  // Merged strobe: any legal strobe action drives it from 0 to 1
  always_comb begin
    raw.strobe_any = strb_a | strb_b | strb_d | ~strb_c;
    raw.data       = sdi;
    raw.ld_a_n     = load_a_n;
    raw.ld_b_n     = load_b_n;
  end

  dacsf_sync #(.W(PIN_BITS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  dacsf_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (synced.strobe_any),
    .rise (shift_ev)
  );

  assign sdi_s = synced.data;
  assign ld_go = ~synced.ld_a_n & ~synced.ld_b_n;

  dacsf_shreg #(.W(DAC_BITS)) u_shreg (
    .clk   (clk),
    .rst   (rst),
    .shift (shift_ev),
    .din   (sdi_s),
    .word  (sr_word),
    .dout  (sdo)
  );

  // DAC register: asynchronous clear has priority over reset and load
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)     dac_word <= '0;
    else if (rst)   dac_word <= '0;
    else if (ld_go) dac_word <= sr_word;
  end
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int DAC_BITS = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                clr_n,
  input logic                shift_ev,
  input logic                sdi_s,
  input logic                ld_go,
  input logic                sdo,
  input logic [DAC_BITS-1:0] sr_word,
  input logic [DAC_BITS-1:0] dac_word
);
  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> sr_word == {$past(sr_word[DAC_BITS-2:0]), $past(sdi_s)}); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_ev |=> $stable(sr_word)); // R5
  AST_SDO_SHIFTED_OUT: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> sdo == $past(sr_word[DAC_BITS-1])); // R6
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_ev |=> $stable(sdo)); // R6
  AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (rst || !clr_n)
    ld_go |=> dac_word == $past(sr_word)); // R7
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !ld_go |=> $stable(dac_word)); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> dac_word == '0); // R9
endmodule

bind dac_serial_front dac_serial_front_chk #(.DAC_BITS(DAC_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_n    (clr_n),
  .shift_ev (shift_ev),
  .sdi_s    (sdi_s),
  .ld_go    (ld_go),
  .sdo      (sdo),
  .sr_word  (sr_word),
  .dac_word (dac_word)
);

// File: tb/dac_serial_front_test.sv
`timescale 1ns/1ps
module dac_serial_front_test;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strb_a = 1'b0, strb_b = 1'b0, strb_c = 1'b1, strb_d = 1'b0;
  logic sdi = 1'b0, load_a_n = 1'b1, load_b_n = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [N-1:0] dac_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] m_sr  = '0;
  logic [N-1:0] m_dac = '0;
  logic         m_sdo = 1'b0;

  always #5 clk = ~clk;

  dac_serial_front #(.DAC_BITS(N)) uut (
    .clk(clk), .rst(rst), .strb_a(strb_a), .strb_b(strb_b), .strb_c(strb_c),
    .strb_d(strb_d), .sdi(sdi), .load_a_n(load_a_n), .load_b_n(load_b_n),
    .clr_n(clr_n), .sdo(sdo), .dac_word(dac_word)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic loads_low();
    return !load_a_n && !load_b_n && clr_n;
  endfunction

  // model update for one accepted shift
  task automatic model_shift(input logic b);
    m_sdo = m_sr[N-1];
    m_sr  = {m_sr[N-2:0], b};
    if (loads_low()) m_dac = m_sr;
  endtask

  // mode 0: strb_a rise, 1: strb_b rise, 2: strb_d rise, 3: strb_c fall
  task automatic shift_bit(input int mode, input logic b);
    sdi = b;
    tick(5);
    case (mode)
      0: strb_a = 1'b1;
      1: strb_b = 1'b1;
      2: strb_d = 1'b1;
      default: strb_c = 1'b0;
    endcase
    tick(5);
    model_shift(b);
    chk(mode == 3 ? "R4 shift on falling strobe" : "R3 shift on rising strobe", {11'd0, sdo}, {11'd0, m_sdo});
    chk("R6/R8 dac after shift", dac_word, m_dac);
    strb_a = 1'b0; strb_b = 1'b0; strb_d = 1'b0; strb_c = 1'b1;
    tick(5);
  endtask

  // one real shift followed by edges that the gating must block
  task automatic blocked_bit(input logic b);
    sdi = b;
    tick(5);
    strb_a = 1'b1;
    tick(5);
    model_shift(b);
    sdi = ~b;
    tick(5);
    strb_b = 1'b1;
    tick(5);
    strb_c = 1'b0;
    tick(5);
    strb_d = 1'b1;
    tick(5);
    strb_a = 1'b0; strb_b = 1'b0; strb_d = 1'b0;
    tick(5);
    strb_c = 1'b1;
    tick(5);
    chk("R5 blocked edges leave sdo", {11'd0, sdo}, {11'd0, m_sdo});
  endtask

  task automatic send_word(input logic [N-1:0] w, input int mode);
    for (int i = N - 1; i >= 0; i--) begin
      int md;
      md = (mode < 0) ? int'($urandom_range(0, 3)) : mode;
      shift_bit(md, w[i]);
    end
  endtask

  task automatic do_load();
    load_a_n = 1'b0; load_b_n = 1'b0;
    tick(5);
    m_dac = m_sr;
    chk("R7 load moves word", dac_word, m_dac);
    load_a_n = 1'b1; load_b_n = 1'b1;
    tick(5);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(5);
    rst = 1'b0;
    tick(2);
    chk("R1 reset dac", dac_word, '0);
    chk("R1 reset sdo", {11'd0, sdo}, '0);

    // R3 first word via strb_a, previous content zero
    send_word(12'hA5C, 0);
    do_load();
    chk("R2 MSB first word A5C", dac_word, 12'hA5C);

    // R4 second word via strb_c fall, sdo carries first word (R6)
    send_word(12'h3F1, 3);
    chk("R8 dac held while loads high", dac_word, 12'hA5C);
    load_a_n = 1'b0;
    tick(5);
    chk("R8 one load low holds", dac_word, 12'hA5C);
    load_a_n = 1'b1; load_b_n = 1'b0;
    tick(5);
    chk("R8 other load low holds", dac_word, 12'hA5C);
    load_b_n = 1'b1;
    tick(1);
    do_load();
    chk("R7 word 3F1", dac_word, 12'h3F1);

    // R3 other rising strobes
    send_word(12'h81E, 1);
    do_load();
    send_word(12'h47B, 2);
    do_load();
    chk("R3 strb_d word", dac_word, 12'h47B);

    // R5 blocked edges
    for (int i = 0; i < N; i++) blocked_bit(1'(i % 3 == 0));
    do_load();
    chk("R5 only gated shifts counted", dac_word, 12'h924);

    // R7 level-sensitive follow, load right after strobe
    load_a_n = 1'b0; load_b_n = 1'b0;
    tick(5);
    m_dac = m_sr;
    send_word(12'h5A3, -1);
    chk("R7 follow while loads low", dac_word, 12'h5A3);

    // R9 asynchronous clear during load
    clr_n = 1'b0;
    m_dac = '0;
    #2;
    chk("R9 clear before clock edge", dac_word, '0);
    tick(5);
    chk("R9 clear beats load", dac_word, '0);
    load_a_n = 1'b1; load_b_n = 1'b1;
    tick(5);
    clr_n = 1'b1;
    tick(5);
    chk("R9 dac stays zero after clear", dac_word, '0);
    do_load();
    chk("R10 shift reg kept through clear", dac_word, 12'h5A3);

    // random words with random strobe modes and blocked bits
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] w;
      w = N'($urandom);
      for (int i = N - 1; i >= 0; i--) begin
        if ($urandom_range(0, 7) == 0) blocked_bit(w[i]);
        else shift_bit(int'($urandom_range(0, 3)), w[i]);
      end
      do_load();
      chk("R2 random word", dac_word, w);
    end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_900_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule